// File: doc/BRIEF.md
# DTR Pin Mode Controller

This block drives the active-low DTR pin of a serial port. A two-bit mode field picks one of four behaviours. The first is the ordinary modem-control output, set by software. The second is receive flow control with hysteresis, based on the receive FIFO fill level. The other two drive the enable of an external RS485 line driver from the transmitter-empty status, one active-low and one active-high. Two clock-select inputs can take over the pin and put either the 1x transmit clock or the Nx baud clock on it instead.

The flow-control decision is held in a one-bit register. The register is set when the fill level reaches the upper threshold and cleared when the level drops below the lower one. It keeps its value while the level lies between the two. The register is updated in every mode, so switching into flow mode shows the current state at once. The transmitter-empty input must be true only when both the transmit FIFO and the shift register are empty. In the RS485 modes the driver enable therefore stays on until the line has returned to its idle marking level after the last stop bit.

Top module: `dtr_pin_ctrl`

## Requirements
- R1: With mode 2'b00 and no clock override, `dtr_n` equals the inverse of `sw_dtr`, in the same cycle.
- R2: When `rx_level >= thr_hi` at a rising clock edge, the flow state is set after that edge. With mode 2'b01 and no override, `dtr_n` then reads 1.
- R3: When `rx_level` is below both `thr_lo` and `thr_hi` at a rising edge, the flow state clears after that edge. With mode 2'b01, `dtr_n` then reads 0.
- R4: When `thr_lo <= rx_level < thr_hi`, the flow state keeps its value. A level equal to `thr_lo` does not clear it.
- R5: With mode 2'b10 and no override, `dtr_n` equals `tx_empty`: the pin is low while the transmitter holds data.
- R6: With mode 2'b11 and no override, `dtr_n` equals the inverse of `tx_empty`.
- R7: While `clk_sel_1x` is 1, `dtr_n` follows `tx_clk_1x`, whatever the mode.
- R8: While `clk_sel_nx` is 1 and `clk_sel_1x` is 0, `dtr_n` follows `baud_clk_nx`.
- R9: When both select inputs are 1, the 1x transmit clock wins.
- R10: Reset (`rst_n` low, asynchronous) clears the flow state. In mode 2'b01 `dtr_n` reads 0 during reset and after it, until the upper threshold is reached.
- R11: The flow state is updated in every mode. If `thr_hi <= thr_lo`, reaching `thr_hi` sets the state, because set has priority over clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Pin behaviour select: 00 modem, 01 flow, 10 RS485 active-low enable, 11 RS485 active-high enable |
| sw_dtr | input | 1 | Software DTR bit, 1 asserts the pin low |
| rx_level | input | LVL_W | Receive FIFO fill level |
| thr_hi | input | LVL_W | Upper flow threshold |
| thr_lo | input | LVL_W | Lower flow threshold |
| tx_empty | input | 1 | Transmit FIFO and shift register both empty |
| clk_sel_1x | input | 1 | Put the 1x transmit clock on the pin |
| clk_sel_nx | input | 1 | Put the Nx baud clock on the pin |
| tx_clk_1x | input | 1 | 1x transmit clock |
| baud_clk_nx | input | 1 | Nx baud-generator clock |
| dtr_n | output | 1 | DTR pin, active low |

## Verification
The only state is the flow bit, so a wrong flow state shows only in mode 01. A missed set or clear is visible on `dtr_n` one clock after the fill level crosses a threshold. A lost hold shows up while the level sits between the thresholds. The bench crosses the thresholds in both directions and parks the level exactly on the lower bound. It also leaves flow mode and comes back, so a state that was not tracked shows on the first cycle back. The combinational paths (modem, RS485, clock override) show a wrong selection or polarity in the same cycle the inputs change.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  typedef enum logic [1:0] {
    DTR_MODEM  = 2'b00,
    DTR_FLOW   = 2'b01,
    DTR_EN_LO  = 2'b10,
    DTR_EN_HI  = 2'b11
  } dtr_mode_e;

  // Next flow state: reaching the upper bound wins, dropping under the lower
  // bound releases, otherwise the state is kept.
  function automatic logic flow_next(input logic cur, input int unsigned lvl,
                                     input int unsigned hi, input int unsigned lo);
    if (lvl >= hi)      return 1'b1;
    else if (lvl < lo)  return 1'b0;
    else                return cur;
  endfunction

  // Pin level for a driver enable: active_high selects the polarity.
  function automatic logic enable_pin(input logic active_high, input logic txe);
    return active_high ? ~txe : txe;
  endfunction

endpackage

// File: rtl/dtr_flow_hyst.sv
module dtr_flow_hyst #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi,
  input  logic [LVL_W-1:0] lo,
  output logic             stop_o
);
  import dtr_pkg::*;

  logic stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= flow_next(stop_q, int'(level), int'(hi), int'(lo));
  end

  assign stop_o = stop_q;
endmodule

// File: rtl/dtr_rs485_en.sv
module dtr_rs485_en (
  input  logic active_high,
  input  logic tx_empty,
  output logic pin_o
);
  import dtr_pkg::*;
  assign pin_o = enable_pin(active_high, tx_empty);
endmodule

// File: rtl/dtr_clk_override.sv
module dtr_clk_override (
  input  logic sel_1x,
  input  logic sel_nx,
  input  logic clk_1x,
  input  logic clk_nx,
  output logic active_o,
  output logic pin_o
);
  assign active_o = sel_1x | sel_nx;
  always_comb begin
    if (sel_1x)      pin_o = clk_1x;
    else if (sel_nx) pin_o = clk_nx;
    else             pin_o = 1'b1;
  end
endmodule

// File: rtl/dtr_pin_ctrl.sv
module dtr_pin_ctrl #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             sw_dtr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic             tx_empty,
  input  logic             clk_sel_1x,
  input  logic             clk_sel_nx,
  input  logic             tx_clk_1x,
  input  logic             baud_clk_nx,
  output logic             dtr_n
);
  import dtr_pkg::*;

  // Named internal events for the checker
  logic      flow_stop;
  logic      rs485_pin;
  logic      ovr_act;
  logic      ovr_pin;
  logic      mode_pin;
  dtr_mode_e mode_e;

  assign mode_e = dtr_mode_e'(mode);

  dtr_flow_hyst #(.LVL_W(LVL_W)) u_flow (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (rx_level),
    .hi     (thr_hi),
    .lo     (thr_lo),
    .stop_o (flow_stop)
  );

  dtr_rs485_en u_en (
    .active_high (mode[0]),
    .tx_empty    (tx_empty),
    .pin_o       (rs485_pin)
  );

  dtr_clk_override u_ovr (
    .sel_1x   (clk_sel_1x),
    .sel_nx   (clk_sel_nx),
    .clk_1x   (tx_clk_1x),
    .clk_nx   (baud_clk_nx),
    .active_o (ovr_act),
    .pin_o    (ovr_pin)
  );

  always_comb begin
    case (mode_e)
      DTR_MODEM: mode_pin = ~sw_dtr;
      DTR_FLOW:  mode_pin = flow_stop;
      default:   mode_pin = rs485_pin;
    endcase
  end

  assign dtr_n = ovr_act ? ovr_pin : mode_pin;
endmodule

// File: rtl/dtr_pin_ctrl_chk.sv
module dtr_pin_ctrl_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             sw_dtr,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] thr_hi,
  input logic [LVL_W-1:0] thr_lo,
  input logic             tx_empty,
  input logic             clk_sel_1x,
  input logic             clk_sel_nx,
  input logic             tx_clk_1x,
  input logic             baud_clk_nx,
  input logic             dtr_n,
  input logic             flow_stop
);
  logic no_ovr;
  assign no_ovr = !clk_sel_1x && !clk_sel_nx;

  assert_modem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && mode == 2'b00) |-> dtr_n == !sw_dtr);

  assert_flow_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= thr_hi) |=> flow_stop);

  assert_flow_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && mode == 2'b01) |-> dtr_n == flow_stop);

  assert_flow_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level < thr_lo && rx_level < thr_hi) |=> !flow_stop);

  assert_flow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= thr_lo && rx_level < thr_hi) |=> $stable(flow_stop));

  assert_en_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && mode == 2'b10) |-> dtr_n == tx_empty);

  assert_en_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (no_ovr && mode == 2'b11) |-> dtr_n == !tx_empty);

  assert_clk1x_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_1x |-> dtr_n == tx_clk_1x);

  assert_clknx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel_1x && clk_sel_nx) |-> dtr_n == baud_clk_nx);

  assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_1x && clk_sel_nx) |-> dtr_n == tx_clk_1x);

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |-> !flow_stop);
endmodule

bind dtr_pin_ctrl dtr_pin_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .sw_dtr      (sw_dtr),
  .rx_level    (rx_level),
  .thr_hi      (thr_hi),
  .thr_lo      (thr_lo),
  .tx_empty    (tx_empty),
  .clk_sel_1x  (clk_sel_1x),
  .clk_sel_nx  (clk_sel_nx),
  .tx_clk_1x   (tx_clk_1x),
  .baud_clk_nx (baud_clk_nx),
  .dtr_n       (dtr_n),
  .flow_stop   (flow_stop)
);

// File: tb/tb_dtr_pin_ctrl.sv
module tb_dtr_pin_ctrl;
  localparam int LVL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic             sw_dtr = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] thr_hi = 8'd12;
  logic [LVL_W-1:0] thr_lo = 8'd4;
  logic             tx_empty = 1'b1;
  logic             clk_sel_1x = 1'b0;
  logic             clk_sel_nx = 1'b0;
  logic             tx_clk_1x = 1'b0;
  logic             baud_clk_nx = 1'b0;
  logic             dtr_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dtr_pin_ctrl #(.LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sw_dtr(sw_dtr),
    .rx_level(rx_level), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .tx_empty(tx_empty), .clk_sel_1x(clk_sel_1x), .clk_sel_nx(clk_sel_nx),
    .tx_clk_1x(tx_clk_1x), .baud_clk_nx(baud_clk_nx), .dtr_n(dtr_n)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       sw;
    logic [7:0] lvl;
    logic [7:0] hi;
    logic [7:0] lo;
    logic       txe;
    logic       s1;
    logic       sn;
    logic       c1;
    logic       cn;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{2'b00,1'b1,8'd0, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1},  // R1 sw set
    '{2'b00,1'b0,8'd0, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,4'd1},  // R1 sw clear
    '{2'b01,1'b0,8'd5, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4},  // R4 hold low
    '{2'b01,1'b0,8'd12,8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,4'd2},  // R2 reach hi
    '{2'b01,1'b0,8'd8, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,4'd4},  // R4 hold high
    '{2'b01,1'b0,8'd4, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,4'd4},  // R4 equal lo
    '{2'b01,1'b0,8'd3, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3},  // R3 below lo
    '{2'b01,1'b0,8'd10,8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4},  // R4 hold low
    '{2'b10,1'b0,8'd0, 8'd12,8'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},  // R5 busy
    '{2'b10,1'b0,8'd0, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,4'd5},  // R5 empty
    '{2'b11,1'b0,8'd0, 8'd12,8'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd6},  // R6 busy
    '{2'b11,1'b0,8'd0, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},  // R6 empty
    '{2'b00,1'b1,8'd0, 8'd12,8'd4,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'd7},  // R7 clk high
    '{2'b00,1'b1,8'd0, 8'd12,8'd4,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd7},  // R7 clk low
    '{2'b00,1'b1,8'd0, 8'd12,8'd4,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,4'd8},  // R8 clk high
    '{2'b11,1'b0,8'd0, 8'd12,8'd4,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd8},  // R8 clk low
    '{2'b00,1'b1,8'd0, 8'd12,8'd4,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd9},  // R9 1x wins
    '{2'b00,1'b1,8'd0, 8'd12,8'd4,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,4'd9},  // R9 1x wins
    '{2'b00,1'b1,8'd20,8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd11}, // R11 set off-mode
    '{2'b01,1'b0,8'd8, 8'd12,8'd4,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,4'd11}  // R11 state kept
  };

  task automatic check(input logic exp, input string tag);
    n_run++;
    if (dtr_n !== exp) begin
      n_fail++;
      $display("FAIL %s: dtr_n=%b expected=%b", tag, dtr_n, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    mode = v.mode; sw_dtr = v.sw; rx_level = v.lvl; thr_hi = v.hi; thr_lo = v.lo;
    tx_empty = v.txe; clk_sel_1x = v.s1; clk_sel_nx = v.sn;
    tx_clk_1x = v.c1; baud_clk_nx = v.cn;
  endtask

  // drive at negedge, clock once, sample mid-high phase
  task automatic step_chk(input logic exp, input string tag);
    @(posedge clk); #5;
    check(exp, tag);
    @(negedge clk);
  endtask

  initial begin
    // R10: reset state, flow bit held clear even with level above hi
    @(negedge clk);
    mode = 2'b00; sw_dtr = 1'b0; #1 check(1'b1, "R1 during reset");
    mode = 2'b01; rx_level = 8'd200;
    @(posedge clk); #5 check(1'b0, "R10 flow clear in reset");
    @(negedge clk);
    rx_level = 8'd0; rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(posedge clk); #5;
      n_run++;
      if (dtr_n !== TBL[i].exp) begin
        n_fail++;
        $display("FAIL R%0d row %0d: dtr_n=%b expected=%b", TBL[i].req, i, dtr_n, TBL[i].exp);
      end
      @(negedge clk);
    end

    // R11: inverted thresholds, set wins
    mode = 2'b01; clk_sel_1x = 1'b0; clk_sel_nx = 1'b0;
    thr_hi = 8'd4; thr_lo = 8'd8; rx_level = 8'd0;
    step_chk(1'b0, "R3 clear before misconfig");
    rx_level = 8'd6; step_chk(1'b1, "R11 set priority");
    rx_level = 8'd3; step_chk(1'b0, "R3 clear under both");
    // R2: top-of-range threshold
    thr_hi = 8'd255; thr_lo = 8'd4; rx_level = 8'd254;
    step_chk(1'b0, "R4 hold just below max");
    rx_level = 8'd255; step_chk(1'b1, "R2 reach max");
    // R10: reset clears a set state
    rst_n = 1'b0; #1 check(1'b0, "R10 async clear");
    @(negedge clk); rx_level = 8'd100; rst_n = 1'b1;
    step_chk(1'b0, "R10 stays clear between thresholds");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule